// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small fully associative translation cache. Each entry holds a virtual page number, a physical page number, a permission field and a 12-bit address-space identifier. A lookup hits only when an entry is valid and both its page number and its identifier tag equal the requested page and the current compare tag. A task switch therefore costs one write to the active-identifier register. The cached translations of other tasks stay in place and become usable again when their identifier is restored.

Each address space can own a pair of identifiers, one for the user view and one for the kernel view. The `kern_mode` input selects which one is used by overwriting the least significant bit of the active identifier. Software uses the invalidate-by-identifier command to retire one identifier before it gives that identifier to another address space. The flush command empties the whole buffer. When no entry is free, a fill evicts the entry that was used least recently.

Top module: `tag_tlb`

## Requirements
- R1: When `lk_valid` is high, `lk_hit` is high in the same cycle if and only if a valid entry's page number equals `lk_vpn` and its tag equals the compare tag. On a hit, `lk_ppn` and `lk_perm` give that entry's stored values. On a miss, both are zero.
- R2: The compare tag, used for both lookups and fills, is the active identifier with bit 0 replaced by `kern_mode`: 0 selects the user view and 1 selects the kernel view.
- R3: A write on `id_we` loads `id_wdata` into the active identifier at the next clock edge. No entry is invalidated by this write, so translations cached under an earlier identifier hit again once that identifier is restored.
- R4: `inv_id_en` clears, at the next edge, every entry whose full 12-bit tag equals `inv_id`. Entries with any other tag are left untouched.
- R5: `flush_all` clears every entry at the next edge, regardless of tag.
- R6: In any cycle where `inv_id_en` or `flush_all` is high, a lookup reports a miss and does not change the recency order.
- R7: A fill writes the lowest-indexed invalid entry if one exists. If the buffer is full, it replaces the least recently used entry. Hits and fills both mark an entry as most recently used. When a fill and a lookup hit occur in the same cycle, only the fill updates the recency order.
- R8: A fill whose page number and compare tag match a valid entry overwrites that entry and does not allocate a second entry.
- R9: A fill presented in the same cycle as `inv_id_en` or `flush_all` is dropped.
- R10: After reset, all entries are invalid and the active identifier is zero. The recency order runs in index order, with entry 0 least recent.
- R11: All 12 tag bits take part in the compare. Two identifiers that differ only in bit 11 never share entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| kern_mode | input | 1 | Selects the kernel identifier of the pair (forces tag bit 0) |
| lk_hit | output | 1 | Lookup hit, combinational |
| lk_ppn | output | PPN_W | Translated physical page number |
| lk_perm | output | PERM_W | Permission bits of the hit entry |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Fill virtual page number |
| fill_ppn | input | PPN_W | Fill physical page number |
| fill_perm | input | PERM_W | Fill permission bits |
| id_we | input | 1 | Load the active identifier |
| id_wdata | input | 12 | New active identifier |
| inv_id_en | input | 1 | Invalidate all entries of one identifier |
| inv_id | input | 12 | Identifier to invalidate |
| flush_all | input | 1 | Invalidate every entry |

## Verification
The hardest state to reach from the ports is a completely full buffer with a known recency order. Only in that state does the replacement choice become visible. The stimulus first flushes the buffer and then fills all sixteen entries with distinct pages. It touches the oldest page with a hit and installs one more page. The eviction must then fall on the second-oldest page while the other fifteen pages still hit. Next, a refill of a page that is already present shows that no further entry is lost. Separate cycles drive a lookup and a fill together with an invalidate, to confirm the forced miss and the dropped fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 12;
  typedef logic [ASID_W-1:0] asid_t;

  // bit 0 of the identifier picks the user or kernel half of a pair
  function automatic asid_t form_tag(asid_t base, logic kern);
    asid_t t;
    t = base;
    t[0] = kern;
    return t;
  endfunction
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int PERM_W = 4,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  asid_t             lk_tag,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  asid_t             fl_tag,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              inv_en,
  input  asid_t             inv_tag,
  input  logic              clr_all,
  output logic [N-1:0]      lk_match,
  output logic [N-1:0]      fl_match,
  output logic [N-1:0]      valid_o,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [PERM_W-1:0] rd_perm
);
  logic [N-1:0]      valid_q;
  logic [VPN_W-1:0]  vpn_q  [N];
  asid_t             tag_q  [N];
  logic [PPN_W-1:0]  ppn_q  [N];
  logic [PERM_W-1:0] perm_q [N];

  // payload arrays: one write port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= fl_vpn;
      tag_q[wr_idx]  <= fl_tag;
      ppn_q[wr_idx]  <= wr_ppn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[g] <= 1'b0;
        end else if (clr_all || (inv_en && tag_q[g] == inv_tag)) begin
          valid_q[g] <= 1'b0;
        end else if (wr_en && wr_idx == IW'(g)) begin
          valid_q[g] <= 1'b1;
        end
      end
      assign lk_match[g] = valid_q[g] && vpn_q[g] == lk_vpn && tag_q[g] == lk_tag;
      assign fl_match[g] = valid_q[g] && vpn_q[g] == fl_vpn && tag_q[g] == fl_tag;
    end
  endgenerate

  // at most one entry matches, so an OR of gated words is the read mux
  always_comb begin
    rd_ppn  = '0;
    rd_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        rd_ppn  = rd_ppn  | ppn_q[i];
        rd_perm = rd_perm | perm_q[i];
      end
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [IW-1:0] age_q [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age_q[i] <= IW'(N - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (touch_idx == IW'(i))
          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx])
          age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IW'(N - 1)) victim = IW'(i);
    end
  end
endmodule

// File: rtl/tag_tlb.sv
module tag_tlb
  import tlb_pkg::*;
#(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int PERM_W = 4,
  localparam int IW    = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              kern_mode,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              id_we,
  input  logic [11:0]       id_wdata,
  input  logic              inv_id_en,
  input  logic [11:0]       inv_id,
  input  logic              flush_all
);
  asid_t         active_q;
  asid_t         cmp_tag;
  logic [N-1:0]  lk_match, fl_match, valid_q;
  logic [PPN_W-1:0]  rd_ppn;
  logic [PERM_W-1:0] rd_perm;
  logic          inv_any, fill_go, touch_en;
  logic [IW-1:0] fill_idx, hit_idx, free_idx, dup_idx, victim, touch_idx;

  always_ff @(posedge clk) begin
    if (rst)        active_q <= '0;
    else if (id_we) active_q <= id_wdata;
  end

  assign cmp_tag = form_tag(active_q, kern_mode);
  assign inv_any = inv_id_en | flush_all;
  assign fill_go = fill_en & ~inv_any;

  tlb_cam #(.N(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_cam (
    .clk(clk), .rst(rst),
    .lk_vpn(lk_vpn), .lk_tag(cmp_tag),
    .fl_vpn(fill_vpn), .fl_tag(cmp_tag),
    .wr_en(fill_go), .wr_idx(fill_idx), .wr_ppn(fill_ppn), .wr_perm(fill_perm),
    .inv_en(inv_id_en), .inv_tag(inv_id), .clr_all(flush_all),
    .lk_match(lk_match), .fl_match(fl_match), .valid_o(valid_q),
    .rd_ppn(rd_ppn), .rd_perm(rd_perm)
  );

  function automatic logic [IW-1:0] enc_last(logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [IW-1:0] first_free(logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (!v[i]) r = IW'(i);
    return r;
  endfunction

  always_comb begin
    dup_idx  = enc_last(fl_match);
    hit_idx  = enc_last(lk_match);
    free_idx = first_free(valid_q);
    if (|fl_match)       fill_idx = dup_idx;
    else if (~&valid_q)  fill_idx = free_idx;
    else                 fill_idx = victim;
  end

  assign lk_hit  = lk_valid & (|lk_match) & ~inv_any;
  assign lk_ppn  = lk_hit ? rd_ppn  : '0;
  assign lk_perm = lk_hit ? rd_perm : '0;

  assign touch_en  = fill_go | lk_hit;
  assign touch_idx = fill_go ? fill_idx : hit_idx;

  tlb_lru #(.N(N)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_idx(touch_idx), .victim(victim)
  );
endmodule

// File: rtl/tlb_checks.sv
module tlb_checks #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          lk_valid,
  input logic          lk_hit,
  input logic          fill_en,
  input logic          id_we,
  input logic          inv_id_en,
  input logic          flush_all,
  input logic [N-1:0]  lk_match,
  input logic [N-1:0]  valid_q,
  input logic [IW-1:0] fill_idx,
  input logic [11:0]   active_q
);
  a_r1_hit_needs_req: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_valid);

  a_r6_inv_forces_miss: assert property (@(posedge clk) disable iff (rst)
    (inv_id_en || flush_all) |-> !lk_hit);

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> valid_q == '0);

  a_r8_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  a_r3_switch_keeps: assert property (@(posedge clk) disable iff (rst)
    (id_we && !fill_en && !inv_id_en && !flush_all) |=> valid_q == $past(valid_q));

  a_r7_fill_lands: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !inv_id_en && !flush_all) |=> valid_q[$past(fill_idx)]);

  a_r9_fill_dropped: assert property (@(posedge clk) disable iff (rst)
    (fill_en && (inv_id_en || flush_all)) |=> $countones(valid_q) <= $countones($past(valid_q)));

  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (valid_q == '0 && active_q == '0));
endmodule

bind tag_tlb tlb_checks #(.N(N)) u_checks (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .fill_en(fill_en), .id_we(id_we), .inv_id_en(inv_id_en), .flush_all(flush_all),
  .lk_match(lk_match), .valid_q(valid_q), .fill_idx(fill_idx), .active_q(active_q)
);

// File: tb/tb_tag_tlb.sv
module tb_tag_tlb;
  logic clk = 1'b0, rst = 1'b1;
  logic lk_valid = 0, kern_mode = 0, fill_en = 0, id_we = 0, inv_id_en = 0, flush_all = 0;
  logic [19:0] lk_vpn = '0, fill_vpn = '0, fill_ppn = '0;
  logic [3:0]  fill_perm = '0;
  logic [11:0] id_wdata = '0, inv_id = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [3:0]  lk_perm;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tag_tlb dut (.*);

  typedef struct packed {
    logic [2:0]  op;    // 0 look, 1 fill, 2 set id, 3 invalidate id, 4 flush
    logic [19:0] vpn;
    logic        kern;
    logic [11:0] id;
    logic [19:0] ppn;
    logic [3:0]  perm;
    logic        hit;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{3'd1, 20'h00010, 1'b0, 12'h000, 20'hAAAAA, 4'h5, 1'b0, 4'd1},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'hAAAAA, 4'h5, 1'b1, 4'd1},  // R1
    '{3'd0, 20'h00010, 1'b1, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd2},  // R2 kernel half empty
    '{3'd1, 20'h00010, 1'b1, 12'h000, 20'hBBBBB, 4'h3, 1'b0, 4'd2},
    '{3'd0, 20'h00010, 1'b1, 12'h000, 20'hBBBBB, 4'h3, 1'b1, 4'd2},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'hAAAAA, 4'h5, 1'b1, 4'd2},
    '{3'd2, 20'h00000, 1'b0, 12'h0A4, 20'h00000, 4'h0, 1'b0, 4'd3},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd3},  // R3 new space misses
    '{3'd1, 20'h00010, 1'b0, 12'h000, 20'hCCCCC, 4'h1, 1'b0, 4'd3},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'hCCCCC, 4'h1, 1'b1, 4'd3},
    '{3'd2, 20'h00000, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd3},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'hAAAAA, 4'h5, 1'b1, 4'd3},  // R3 old entry kept
    '{3'd3, 20'h00000, 1'b0, 12'h001, 20'h00000, 4'h0, 1'b0, 4'd4},
    '{3'd0, 20'h00010, 1'b1, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd4},  // R4 removed
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'hAAAAA, 4'h5, 1'b1, 4'd4},  // R4 other id kept
    '{3'd2, 20'h00000, 1'b0, 12'h0A5, 20'h00000, 4'h0, 1'b0, 4'd2},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'hCCCCC, 4'h1, 1'b1, 4'd2},  // R2 bit 0 forced
    '{3'd0, 20'h00011, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd1},
    '{3'd2, 20'h00000, 1'b0, 12'hFFE, 20'h00000, 4'h0, 1'b0, 4'd11},
    '{3'd1, 20'h00020, 1'b0, 12'h000, 20'hDDDDD, 4'h7, 1'b0, 4'd11},
    '{3'd2, 20'h00000, 1'b0, 12'h7FE, 20'h00000, 4'h0, 1'b0, 4'd11},
    '{3'd0, 20'h00020, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd11}, // R11 top bit differs
    '{3'd2, 20'h00000, 1'b0, 12'hFFE, 20'h00000, 4'h0, 1'b0, 4'd11},
    '{3'd0, 20'h00020, 1'b0, 12'h000, 20'hDDDDD, 4'h7, 1'b1, 4'd11},
    '{3'd2, 20'h00000, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd5},
    '{3'd4, 20'h00000, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd5},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd5},  // R5
    '{3'd2, 20'h00000, 1'b0, 12'h0A4, 20'h00000, 4'h0, 1'b0, 4'd5},
    '{3'd0, 20'h00010, 1'b0, 12'h000, 20'h00000, 4'h0, 1'b0, 4'd5}
  };

  task automatic cmp(string req, logic eh, logic [19:0] ep, logic [3:0] em);
    checks++;
    if (lk_hit !== eh || lk_ppn !== ep || lk_perm !== em) begin
      fails++;
      $display("FAIL %s vpn=%h: hit/ppn/perm got %b/%h/%h expected %b/%h/%h",
               req, lk_vpn, lk_hit, lk_ppn, lk_perm, eh, ep, em);
    end
  endtask

  task automatic idle_after_edge();
    @(posedge clk); #1;
    lk_valid = 0; fill_en = 0; id_we = 0; inv_id_en = 0; flush_all = 0;
  endtask

  task automatic look(logic [19:0] v, logic k, logic eh, logic [19:0] ep, logic [3:0] em, string req);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v; kern_mode = k;
    #1 cmp(req, eh, ep, em);
    idle_after_edge();
  endtask

  task automatic fill(logic [19:0] v, logic k, logic [19:0] p, logic [3:0] m);
    @(negedge clk);
    fill_en = 1; fill_vpn = v; kern_mode = k; fill_ppn = p; fill_perm = m;
    idle_after_edge();
  endtask

  task automatic setid(logic [11:0] id);
    @(negedge clk); id_we = 1; id_wdata = id;
    idle_after_edge();
  endtask

  task automatic do_flush();
    @(negedge clk); flush_all = 1;
    idle_after_edge();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R10: empty after reset, identifier zero in both halves
    look(20'h00000, 1'b0, 1'b0, 20'h0, 4'h0, "R10");
    look(20'h00010, 1'b1, 1'b0, 20'h0, 4'h0, "R10");

    for (int i = 0; i < NV; i++) begin
      vec_t v = VT[i];
      string tag = $sformatf("R%0d vec%0d", v.req, i);
      case (v.op)
        3'd0: look(v.vpn, v.kern, v.hit, v.hit ? v.ppn : 20'h0, v.hit ? v.perm : 4'h0, tag);
        3'd1: fill(v.vpn, v.kern, v.ppn, v.perm);
        3'd2: setid(v.id);
        3'd3: begin
          @(negedge clk); inv_id_en = 1; inv_id = v.id;
          idle_after_edge();
        end
        default: do_flush();
      endcase
    end

    // R7: fill all entries, touch the oldest, then force one eviction
    setid(12'h000);
    do_flush();
    for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 1'b0, 20'h10000 + 20'(i), 4'h2);
    look(20'h00100, 1'b0, 1'b1, 20'h10000, 4'h2, "R7");
    fill(20'h00200, 1'b0, 20'h22222, 4'h6);
    look(20'h00101, 1'b0, 1'b0, 20'h0, 4'h0, "R7 evicted LRU");
    look(20'h00100, 1'b0, 1'b1, 20'h10000, 4'h2, "R7");
    look(20'h00200, 1'b0, 1'b1, 20'h22222, 4'h6, "R7");
    for (int i = 2; i < 16; i++)
      look(20'h00100 + 20'(i), 1'b0, 1'b1, 20'h10000 + 20'(i), 4'h2, "R7 survivors");

    // R8: refill of a present page replaces it, nothing else is lost
    fill(20'h00105, 1'b0, 20'h55555, 4'h9);
    look(20'h00105, 1'b0, 1'b1, 20'h55555, 4'h9, "R8");
    look(20'h00100, 1'b0, 1'b1, 20'h10000, 4'h2, "R8");
    look(20'h00200, 1'b0, 1'b1, 20'h22222, 4'h6, "R8");
    for (int i = 2; i < 16; i++)
      if (i != 5) look(20'h00100 + 20'(i), 1'b0, 1'b1, 20'h10000 + 20'(i), 4'h2, "R8 no eviction");

    // R6 / R9: lookup and fill alongside an invalidate of an unrelated id
    do_flush();
    fill(20'h00300, 1'b0, 20'h33333, 4'h1);
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'h00300; kern_mode = 0; inv_id_en = 1; inv_id = 12'h055;
    #1 cmp("R6 miss during invalidate", 1'b0, 20'h0, 4'h0);
    idle_after_edge();
    look(20'h00300, 1'b0, 1'b1, 20'h33333, 4'h1, "R6 entry kept");
    @(negedge clk);
    fill_en = 1; fill_vpn = 20'h00301; fill_ppn = 20'h44444; fill_perm = 4'h3;
    inv_id_en = 1; inv_id = 12'h055;
    idle_after_edge();
    look(20'h00301, 1'b0, 1'b0, 20'h0, 4'h0, "R9 fill dropped");
    @(negedge clk);
    lk_valid = 1; lk_vpn = 20'h00300; flush_all = 1;
    #1 cmp("R6 miss during flush", 1'b0, 20'h0, 4'h0);
    idle_after_edge();
    look(20'h00300, 1'b0, 1'b0, 20'h0, 4'h0, "R5");

    // R10: reset mid-run clears entries and identifier
    setid(12'h3C0);
    fill(20'h00400, 1'b0, 20'h77777, 4'hF);
    @(negedge clk); rst = 1;
    @(posedge clk); #1 rst = 0;
    look(20'h00400, 1'b0, 1'b0, 20'h0, 4'h0, "R10 entries cleared");
    fill(20'h00400, 1'b0, 20'h77777, 4'hF);
    setid(12'h000);
    look(20'h00400, 1'b0, 1'b1, 20'h77777, 4'hF, "R10 id back to zero");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule